// File: doc/BRIEF.md
# Edge-Triggered Prioritized Interrupt Inputs

This block accepts six external interrupt request lines, numbered 1 to 6, that arrive asynchronously to the system clock. Each line passes through a two-flop synchronizer. The block then compares the current synchronized sample with the previous one to detect a transition. For every line, software chooses the direction that counts as an event: a falling transition or a rising transition. A detected event sets a sticky pending flag. The flag stays set until software writes a one to its position in the pending register.

Each line also has its own mask bit and its own 3-bit priority level. A level of zero takes the line out of arbitration. On every clock the block looks at the pending lines that are unmasked and have a nonzero level, and picks the one with the highest level. When two lines share that level, the lower-numbered line wins. The result goes out through a register as an encoded level and the number of the winning line. The interrupt acknowledge handshake and vector lookup live elsewhere in the system.

Top module: `irq_edge_arb`

## Requirements
- R1: An input transition in the direction chosen by its polarity bit (register 0, bit k-1 for input k; 1 = rising, 0 = falling) sets pending bit k-1. The pending bit can be read after the third rising clock edge that follows the input change.
- R2: A transition in the direction opposite to the polarity bit sets no pending bit.
- R3: A pending bit stays set until a write to register 3 has a one at its position. Bits written as zero leave their pending bits unchanged.
- R4: If a detected edge and a clear write for the same input land in the same cycle, the pending bit ends up set.
- R5: A mask bit of 1 (register 1, bit k-1) keeps input k out of arbitration but does not clear its pending bit. Writing the mask bit back to 0 lets the held request take part in arbitration again.
- R6: The level of input k sits in register 2, bits [3(k-1)+2 : 3(k-1)]. A level of 0 keeps the input out of arbitration even while it is pending and unmasked.
- R7: One clock after the arbitration inputs change, irq_level shows the highest level among the pending, unmasked, nonzero-level inputs, and irq_id shows that input's number (1 to 6).
- R8: When several eligible inputs share the highest level, irq_id shows the lowest-numbered of them.
- R9: When no input is eligible, irq_level and irq_id are both 0.
- R10: After reset, all polarity bits are 0, all mask bits are 1 (register 1 reads 0x3F), all levels are 0, no bit is pending, and both outputs are 0.
- R11: rd_data returns the addressed register (0 polarity, 1 mask, 2 levels, 3 pending), zero-extended, in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 6 | Asynchronous request lines; bit k-1 is input k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| irq_level | output | 3 | Level of the winning request, 0 when none |
| irq_id | output | 3 | Number of the winning input, 0 when none |

## Verification
The bench builds the block with its default parameters: six inputs, 3-bit levels, two synchronizer stages and a 32-bit data path. With these values every input number 1 to 6 and every level up to 7 can be driven, so the tests can cover a tie at the top level and a line held at level zero. Two synchronizer stages fix the edge-to-pending latency at three edges. The bench relies on that to make an edge and a clear write arrive in the same cycle.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    // Register selector; offsets are what software decodes
    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_POLARITY = 2'd0,
        SEL_MASK     = 2'd1,
        SEL_LEVEL    = 2'd2,
        SEL_PENDING  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_sync_edge.sv
// Synchronizer plus one-cycle edge detector for a single request line.
module irq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    logic synced;
    logic prev;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // chain[STAGES-1] is the synchronized value, chain[STAGES] the previous one
    assign synced = st_q.chain[STAGES-1];
    assign prev   = st_q.chain[STAGES];
    assign hit    = rise_sel ? (synced & ~prev) : (~synced & prev);

endmodule

// File: rtl/irq_cfg_regs.sv
// Polarity, mask, level and sticky pending registers with read mux.
module irq_cfg_regs
    import irq_edge_pkg::*;
#(
    parameter int unsigned NUM_IN = 6,
    parameter int unsigned LVL_W  = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [REG_ADDR_W-1:0]   rd_addr,
    input  logic [NUM_IN-1:0]       hit,
    output logic [NUM_IN-1:0]       pol_q,
    output logic [NUM_IN-1:0]       mask_q,
    output logic [NUM_IN*LVL_W-1:0] lvl_q,
    output logic [NUM_IN-1:0]       pend_q,
    output logic [DATA_W-1:0]       rd_data
);

    localparam int unsigned LVL_BITS = NUM_IN * LVL_W;

    typedef struct packed {
        logic [NUM_IN-1:0]   pol;
        logic [NUM_IN-1:0]   mask;
        logic [LVL_BITS-1:0] lvl;
        logic [NUM_IN-1:0]   pend;
    } cfg_t;

    cfg_t st_d, st_q;

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:LVL_BITS];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_POLARITY: st_d.pol  = wr_data[NUM_IN-1:0];
                SEL_MASK:     st_d.mask = wr_data[NUM_IN-1:0];
                SEL_LEVEL:    st_d.lvl  = wr_data[LVL_BITS-1:0];
                SEL_PENDING:  st_d.pend = st_q.pend & ~wr_data[NUM_IN-1:0];
                default:      st_d = st_q;
            endcase
        end
        // a fresh edge overrides a simultaneous clear
        st_d.pend = st_d.pend | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pol  <= '0;
            st_q.mask <= '1;
            st_q.lvl  <= '0;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            SEL_POLARITY: rd_data[NUM_IN-1:0]   = st_q.pol;
            SEL_MASK:     rd_data[NUM_IN-1:0]   = st_q.mask;
            SEL_LEVEL:    rd_data[LVL_BITS-1:0] = st_q.lvl;
            SEL_PENDING:  rd_data[NUM_IN-1:0]   = st_q.pend;
            default:      rd_data = '0;
        endcase
    end

    assign pol_q  = st_q.pol;
    assign mask_q = st_q.mask;
    assign lvl_q  = st_q.lvl;
    assign pend_q = st_q.pend;

endmodule

// File: rtl/irq_prio_arb.sv
// Combinational level arbiter; ties go to the lowest index.
module irq_prio_arb #(
    parameter int unsigned NUM_IN = 6,
    parameter int unsigned LVL_W  = 3,
    parameter int unsigned ID_W   = 3
) (
    input  logic [NUM_IN-1:0]       pend,
    input  logic [NUM_IN-1:0]       mask,
    input  logic [NUM_IN*LVL_W-1:0] lvl_flat,
    output logic [LVL_W-1:0]        win_lvl,
    output logic [ID_W-1:0]         win_id
);

    logic [LVL_W-1:0]  lvl_arr [NUM_IN];
    logic [NUM_IN-1:0] elig;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_unpack
        assign lvl_arr[g] = lvl_flat[g*LVL_W +: LVL_W];
        assign elig[g]    = pend[g] & ~mask[g] & (|lvl_flat[g*LVL_W +: LVL_W]);
    end

    always_comb begin
        win_lvl = '0;
        win_id  = '0;
        // strict greater-than keeps the earliest index on a tie
        for (int i = 0; i < NUM_IN; i++) begin
            if (elig[i] && (lvl_arr[i] > win_lvl)) begin
                win_lvl = lvl_arr[i];
                win_id  = ID_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/irq_edge_arb.sv
// Top: per-line synchronizers, register file, arbiter and output register.
module irq_edge_arb
    import irq_edge_pkg::*;
#(
    parameter int unsigned NUM_IN      = 6,
    parameter int unsigned LVL_W       = 3,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned ID_W       = $clog2(NUM_IN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     irq_in,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [LVL_W-1:0]      irq_level,
    output logic [ID_W-1:0]       irq_id
);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [ID_W-1:0]  id;
    } out_t;

    logic [NUM_IN-1:0]       hit_w;
    logic [NUM_IN-1:0]       pol_w;
    logic [NUM_IN-1:0]       mask_w;
    logic [NUM_IN*LVL_W-1:0] lvl_w;
    logic [NUM_IN-1:0]       pend_w;
    logic [LVL_W-1:0]        win_lvl_w;
    logic [ID_W-1:0]         win_id_w;

    out_t out_d, out_q;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        irq_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (irq_in[g]),
            .rise_sel (pol_w[g]),
            .hit      (hit_w[g])
        );
    end

    irq_cfg_regs #(
        .NUM_IN (NUM_IN),
        .LVL_W  (LVL_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .hit     (hit_w),
        .pol_q   (pol_w),
        .mask_q  (mask_w),
        .lvl_q   (lvl_w),
        .pend_q  (pend_w),
        .rd_data (rd_data)
    );

    irq_prio_arb #(
        .NUM_IN (NUM_IN),
        .LVL_W  (LVL_W),
        .ID_W   (ID_W)
    ) u_arb (
        .pend     (pend_w),
        .mask     (mask_w),
        .lvl_flat (lvl_w),
        .win_lvl  (win_lvl_w),
        .win_id   (win_id_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.lvl = win_lvl_w;
        out_d.id  = win_id_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_level = out_q.lvl;
    assign irq_id    = out_q.id;

endmodule

// File: rtl/irq_edge_arb_chk.sv
module irq_edge_arb_chk #(
    parameter int unsigned NUM_IN = 6,
    parameter int unsigned LVL_W  = 3,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ID_W  = $clog2(NUM_IN + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [1:0]              wr_addr,
    input logic [DATA_W-1:0]       wr_data,
    input logic [NUM_IN-1:0]       pend_q,
    input logic [NUM_IN-1:0]       mask_q,
    input logic [NUM_IN*LVL_W-1:0] lvl_q,
    input logic [LVL_W-1:0]        irq_level,
    input logic [ID_W-1:0]         irq_id
);

    logic [NUM_IN-1:0] clr_vec;
    logic [NUM_IN-1:0] lvl_nz;
    logic              unused_data_hi;

    assign clr_vec        = (wr_en && wr_addr == 2'd3) ? wr_data[NUM_IN-1:0] : '0;
    assign unused_data_hi = ^wr_data[DATA_W-1:NUM_IN];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_nz
        assign lvl_nz[g] = |lvl_q[g*LVL_W +: LVL_W];
    end

    // pending bits only fall where a clear was written
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

    // the winner was pending and unmasked in the cycle it was chosen
    assert_winner_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id != '0) |->
        ((($past(pend_q & ~mask_q) >> (int'(irq_id) - 1)) & NUM_IN'(1)) != '0));

    // the reported level is the winner's programmed level
    assert_level_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id != '0) |->
        (irq_level == LVL_W'($past(lvl_q) >> (LVL_W * (int'(irq_id) - 1)))));

    assert_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id <= ID_W'(NUM_IN));

    // any eligible request yields a nonzero output next cycle
    assert_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & ~mask_q & lvl_nz)) |=> (irq_level != '0));

    // level and id are zero together
    assert_idle_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) == (irq_id == '0));

endmodule

bind irq_edge_arb irq_edge_arb_chk #(
    .NUM_IN (NUM_IN),
    .LVL_W  (LVL_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pend_q    (pend_w),
    .mask_q    (mask_w),
    .lvl_q     (lvl_w),
    .irq_level (irq_level),
    .irq_id    (irq_id)
);

// File: tb/sim_irq_edge_arb.sv
`timescale 1ns/1ps
module sim_irq_edge_arb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  irq_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq_level;
    logic [2:0]  irq_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_edge_arb u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_level (irq_level),
        .irq_id    (irq_id)
    );

    localparam logic [1:0] A_POL = 2'd0, A_MASK = 2'd1, A_LVL = 2'd2, A_PEND = 2'd3;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic check_out(input string tag, input logic [2:0] lvl, input logic [2:0] id);
        wait_n(3);
        check({tag, " level"}, {29'd0, irq_level}, {29'd0, lvl});
        check({tag, " id"},    {29'd0, irq_id},    {29'd0, id});
    endtask

    function automatic logic [31:0] pack_lvl(input logic [2:0] l1, l2, l3, l4, l5, l6);
        return {14'd0, l6, l5, l4, l3, l2, l1};
    endfunction

    // pulse the lines high then low; falling polarity latches on the drop
    task automatic fire(input logic [5:0] bits);
        @(negedge clk); irq_in = irq_in | bits;
        wait_n(5);
        @(negedge clk); irq_in = irq_in & ~bits;
        wait_n(5);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd_reg(A_POL, d);  check("R10 polarity reset", d, 32'h0);
        rd_reg(A_MASK, d); check("R10 mask reset", d, 32'h3F);
        rd_reg(A_LVL, d);  check("R10 level reset", d, 32'h0);
        rd_reg(A_PEND, d); check("R10 pending reset", d, 32'h0);
        check("R10 level out", {29'd0, irq_level}, 32'h0);
        check("R10 id out", {29'd0, irq_id}, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr_reg(A_POL, 32'hFFFF_FF2A);
        rd_reg(A_POL, d);  check("R11 polarity readback", d, 32'h2A);
        wr_reg(A_LVL, pack_lvl(3'd1, 3'd7, 3'd2, 3'd5, 3'd4, 3'd6));
        rd_reg(A_LVL, d);  check("R11 level readback", d, pack_lvl(3'd1, 3'd7, 3'd2, 3'd5, 3'd4, 3'd6));
        wr_reg(A_POL, 32'h0);
        wr_reg(A_LVL, 32'h0);
    endtask

    task automatic t_falling;
        logic [31:0] d;
        @(negedge clk); irq_in[0] = 1'b1;
        wait_n(5);
        rd_reg(A_PEND, d); check("R2 rise ignored on falling input", d, 32'h0);
        @(negedge clk); irq_in[0] = 1'b0;
        wait_n(5);
        rd_reg(A_PEND, d); check("R1 falling edge latched", d, 32'h01);
        wr_reg(A_PEND, 32'h3F);
    endtask

    task automatic t_rising;
        logic [31:0] d;
        wr_reg(A_POL, 32'h04);
        @(negedge clk); irq_in[2] = 1'b1;
        wait_n(5);
        rd_reg(A_PEND, d); check("R1 rising edge latched", d, 32'h04);
        wr_reg(A_PEND, 32'h04);
        @(negedge clk); irq_in[2] = 1'b0;
        wait_n(5);
        rd_reg(A_PEND, d); check("R2 fall ignored on rising input", d, 32'h0);
        wr_reg(A_POL, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        fire(6'b000011);
        rd_reg(A_PEND, d); check("R3 two pending", d, 32'h03);
        wr_reg(A_PEND, 32'h0);
        rd_reg(A_PEND, d); check("R3 zero write keeps bits", d, 32'h03);
        wr_reg(A_PEND, 32'h01);
        rd_reg(A_PEND, d); check("R3 clear one bit", d, 32'h02);
        wr_reg(A_PEND, 32'h02);
        rd_reg(A_PEND, d); check("R3 clear last bit", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr_reg(A_POL, 32'h08);
        @(negedge clk); irq_in[3] = 1'b1;
        @(posedge clk);             // first synchronizer stage
        @(posedge clk);             // second stage: edge seen now
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_PEND; wr_data = 32'h08;
        @(posedge clk);             // edge and clear land together
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        rd_reg(A_PEND, d); check("R4 edge wins over clear", d, 32'h08);
        wr_reg(A_PEND, 32'h08);
        rd_reg(A_PEND, d); check("R4 later clear works", d, 32'h0);
        wr_reg(A_POL, 32'h0);
        @(negedge clk); irq_in[3] = 1'b0;
        wait_n(5);
        wr_reg(A_PEND, 32'h3F);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr_reg(A_LVL, pack_lvl(3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd0));
        wr_reg(A_MASK, 32'h0);
        fire(6'b010000);
        check_out("R5 unmasked request", 3'd4, 3'd5);
        wr_reg(A_MASK, 32'h10);
        check_out("R5 masked hides", 3'd0, 3'd0);
        rd_reg(A_PEND, d); check("R5 mask keeps pending", d, 32'h10);
        wr_reg(A_MASK, 32'h0);
        check_out("R5 unmask restores", 3'd4, 3'd5);
        wr_reg(A_PEND, 32'h3F);
        check_out("R9 empty after clear", 3'd0, 3'd0);
    endtask

    task automatic t_level_zero;
        fire(6'b100000);
        check_out("R6 level zero excluded", 3'd0, 3'd0);
        wr_reg(A_LVL, pack_lvl(3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7));
        check_out("R6 level seven presents", 3'd7, 3'd6);
        wr_reg(A_PEND, 32'h3F);
    endtask

    task automatic t_priority;
        wr_reg(A_LVL, pack_lvl(3'd2, 3'd5, 3'd3, 3'd0, 3'd0, 3'd0));
        fire(6'b000111);
        check_out("R7 highest level", 3'd5, 3'd2);
        wr_reg(A_PEND, 32'h02);
        check_out("R7 next highest", 3'd3, 3'd3);
        wr_reg(A_PEND, 32'h04);
        check_out("R7 lowest remaining", 3'd2, 3'd1);
        wr_reg(A_PEND, 32'h3F);
    endtask

    task automatic t_tie;
        wr_reg(A_LVL, pack_lvl(3'd1, 3'd6, 3'd2, 3'd6, 3'd3, 3'd0));
        fire(6'b011111);
        check_out("R8 tie lowest number", 3'd6, 3'd2);
        wr_reg(A_MASK, 32'h02);
        check_out("R8 tie after mask", 3'd6, 3'd4);
        wr_reg(A_MASK, 32'h0A);
        check_out("R7 below tie", 3'd3, 3'd5);
        wr_reg(A_PEND, 32'h3F);
        check_out("R9 none pending", 3'd0, 3'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired before tests completed");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_readback();
        t_falling();
        t_rising();
        t_w1c();
        t_collide();
        t_mask();
        t_level_zero();
        t_priority();
        t_tie();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule